// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O peripheral. It serves up to three banks of 32 pins each. Software reaches it over a plain register bus with an address, a write enable, write data and read data, always 32 bits wide. Each bank holds a pin direction word, an output latch, rising and falling edge enables, a sticky edge-status word and an interrupt mask. The latch is changed only through separate write-one-to-set and write-one-to-clear words, so two agents that touch different pins of one bank never need a read-modify-write.

Pad inputs pass through a two-flop synchroniser before anything else sees them. An edge is a change between the synchronised value and its value one cycle earlier. An edge whose polarity is enabled sets that pin's status bit, which stays set until software writes a one to it. A single interrupt output is the OR, over all banks, of the status bits that the mask lets through. Registers of one kind sit at adjacent words for successive banks, so the bank number picks a 4-byte step within each register kind.

Top module: `banked_gpio`

## Requirements
- R1: Registers are 32-bit words at byte address base + 4*bank, with bank in 0..NUM_BANKS-1. The bases are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, interrupt mask 0x9C.
- R2: After reset, every register reads zero except the interrupt mask, which reads 0xFFFFFFFF in every bank. `pad_out`, `pad_oe` and `irq` are all zero.
- R3: A write to the set word drives to 1 each latch bit whose written bit is 1 and leaves the other latch bits unchanged. A read of the set or the clear word returns the latch.
- R4: A write to the clear word drives to 0 each latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R5: `pad_oe` bit i equals direction bit i (1 = output) and `pad_out` bit i equals latch bit i. Both change in the cycle after the write.
- R6: The level word returns the synchronised pad input whatever the direction bits hold. A pad change is visible two clock edges after it is applied. Writes to the level word are ignored.
- R7: A status bit is set on a 0-to-1 change of its synchronised input when its rising enable bit is 1, or on a 1-to-0 change when its falling enable bit is 1. Changes of a polarity that is not enabled set nothing. The bit is set on the third clock edge after the pad changes.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: When a new enabled edge and a write-one clear of the same status bit meet in one cycle, the bit ends up 1.
- R10: `irq` is 1 exactly when some bank has a status bit that is 1 and whose mask bit is 1. A change of status or mask shows on `irq` in the same cycle as the register change.
- R11: Reads of unmapped word addresses return zero, and so do reads of addresses that are not 4-byte aligned. Writes to either kind of address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Asynchronous pad inputs |
| pad_out | output | NUM_BANKS*32 | Output latch value per pin |
| pad_oe | output | NUM_BANKS*32 | Output enable per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The edge detector is tried with four kinds of pin changes: rising changes on a pin that only has rising enabled, rising changes on a pin that only has falling enabled, falling changes on both kinds of pin, and a falling change timed to meet a status clear in the same cycle. Together these separate polarity selection, stickiness and the priority of a set over a clear. Output latch patterns with disjoint and overlapping set and clear words show whether unwritten bits are kept. Wide pad patterns read back with direction set to output show that the level word follows the pad rather than the latch. Writes to the level word, to unmapped offsets and to misaligned addresses, followed by reads of neighbouring registers, show that such writes leak into no register.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   localparam int WORD_W      = 32;
   localparam int NUM_KINDS   = 7;
   localparam int KIND_STRIDE = 12;
   localparam int BANK_STEP   = 4;
   localparam int MASK_BASE   = 'h9C;
   localparam int MAX_BANKS   = 3;
   localparam int DEC_W       = 16;

   typedef enum logic [2:0] {
      K_LEVEL = 3'd0,
      K_DIR   = 3'd1,
      K_SET   = 3'd2,
      K_CLR   = 3'd3,
      K_RISE  = 3'd4,
      K_FALL  = 3'd5,
      K_STAT  = 3'd6,
      K_MASK  = 3'd7
   } reg_kind_e;

   typedef struct packed {
      logic      hit;
      reg_kind_e kind;
      logic [1:0] bank;
   } reg_sel_t;

   function automatic reg_sel_t decode_addr(input logic [DEC_W-1:0] a, input int nbanks);
      reg_sel_t s;
      s = '{hit: 1'b0, kind: K_LEVEL, bank: 2'd0};
      for (int b = 0; b < MAX_BANKS; b++) begin
         if (b < nbanks) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
               if (a == DEC_W'(k * KIND_STRIDE + b * BANK_STEP)) begin
                  s.hit  = 1'b1;
                  s.kind = reg_kind_e'(k);
                  s.bank = 2'(b);
               end
            end
            if (a == DEC_W'(MASK_BASE + b * BANK_STEP)) begin
               s.hit  = 1'b1;
               s.kind = K_MASK;
               s.bank = 2'(b);
            end
         end
      end
      return s;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int             W        = 32,
   parameter logic [W-1:0]   MASK_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] wdata,
   input  logic         wr_dir,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic         wr_rise,
   input  logic         wr_fall,
   input  logic         wr_stat,
   input  logic         wr_mask,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] rise_q,
   output logic [W-1:0] fall_q,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] mask_q
);

   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] clr_bits;

   always_comb begin
      hit      = (pin_s & ~prev_q & rise_q) | (~pin_s & prev_q & fall_q);
      clr_bits = wr_stat ? wdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= pin_s;
         stat_q <= (stat_q & ~clr_bits) | hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         mask_q <= MASK_RST;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_set)  out_q  <= out_q | wdata;
         else if (wr_clr) out_q <= out_q & ~wdata;
         if (wr_rise) rise_q <= wdata;
         if (wr_fall) fall_q <= wdata;
         if (wr_mask) mask_q <= wdata;
      end
   end

   // R8
   status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((($past(stat_q) & ~($past(wr_stat) ? $past(wdata) : '0)) & ~stat_q)) == '0))
      else $error("status bit lost without a write-one clear");

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(hit) & ~stat_q) == '0))
      else $error("detected edge did not leave its status bit set");

   // R3
   latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_set) |-> ((out_q & $past(wdata)) == $past(wdata)))
      else $error("set write did not raise latch bits");

   // R4
   latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_clr) && !$past(wr_set)) |-> ((out_q & $past(wdata)) == '0))
      else $error("clear write did not lower latch bits");

endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
   import gpio_ctrl_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_we,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
   output logic [NUM_BANKS*BANK_W-1:0] pad_out,
   output logic [NUM_BANKS*BANK_W-1:0] pad_oe,
   output logic                        irq
);

   localparam int PIN_W = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("banked_gpio: NUM_BANKS must be 1..3");
   end
   if (BANK_W != WORD_W) begin : g_bad_width
      $error("banked_gpio: BANK_W must equal the bus word width");
   end
   if (ADDR_W < 8 || ADDR_W > DEC_W) begin : g_bad_addr
      $error("banked_gpio: ADDR_W must be 8..16");
   end

   logic [PIN_W-1:0] pin_s;
   reg_sel_t         sel;

   logic [BANK_W-1:0] dir_w  [NUM_BANKS];
   logic [BANK_W-1:0] out_w  [NUM_BANKS];
   logic [BANK_W-1:0] rise_w [NUM_BANKS];
   logic [BANK_W-1:0] fall_w [NUM_BANKS];
   logic [BANK_W-1:0] stat_w [NUM_BANKS];
   logic [BANK_W-1:0] mask_w [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;

   assign sel = decode_addr(DEC_W'(bus_addr), NUM_BANKS);

   gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(pad_in),
      .sync_o (pin_s)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic here;
      assign here = bus_we && sel.hit && (sel.bank == 2'(b));

      gpio_bank #(.W(BANK_W), .MASK_RST('1)) i_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_s  (pin_s[b*BANK_W +: BANK_W]),
         .wdata  (bus_wdata),
         .wr_dir (here && sel.kind == K_DIR),
         .wr_set (here && sel.kind == K_SET),
         .wr_clr (here && sel.kind == K_CLR),
         .wr_rise(here && sel.kind == K_RISE),
         .wr_fall(here && sel.kind == K_FALL),
         .wr_stat(here && sel.kind == K_STAT),
         .wr_mask(here && sel.kind == K_MASK),
         .dir_q  (dir_w[b]),
         .out_q  (out_w[b]),
         .rise_q (rise_w[b]),
         .fall_q (fall_w[b]),
         .stat_q (stat_w[b]),
         .mask_q (mask_w[b])
      );

      assign pad_out[b*BANK_W +: BANK_W] = out_w[b];
      assign pad_oe [b*BANK_W +: BANK_W] = dir_w[b];
      assign bank_irq[b] = |(stat_w[b] & mask_w[b]);
   end

   assign irq = |bank_irq;

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (sel.hit && sel.bank == 2'(b)) begin
            unique case (sel.kind)
               K_LEVEL:       bus_rdata = pin_s[b*BANK_W +: BANK_W];
               K_DIR:         bus_rdata = dir_w[b];
               K_SET, K_CLR:  bus_rdata = out_w[b];
               K_RISE:        bus_rdata = rise_w[b];
               K_FALL:        bus_rdata = fall_w[b];
               K_STAT:        bus_rdata = stat_w[b];
               K_MASK:        bus_rdata = mask_w[b];
               default:       bus_rdata = '0;
            endcase
         end
      end
   end

   // R11
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel.hit |-> (bus_rdata == '0))
      else $error("unmapped read returned nonzero data");

   // R5
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> $stable(pad_oe))
      else $error("output enables moved without a bus write");

endmodule

// File: tb/test_banked_gpio.sv
module test_banked_gpio;

   localparam int NB = 3;
   localparam int NP = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = 8'h60;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   banked_gpio #(.NUM_BANKS(NB)) i_banked_gpio (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // behavioural reference
   bit [31:0] m_dir [NB], m_out [NB], m_rise [NB], m_fall [NB], m_stat [NB], m_mask [NB];
   bit [NP-1:0] m_s1, m_s2, m_prev;

   function automatic bit map_addr(input int a, output int kind, output int bank);
      kind = 0; bank = 0;
      if (a % 4 != 0) return 0;
      if (a < 'h54) begin
         kind = a / 12; bank = (a % 12) / 4;
         return bank < NB;
      end
      if (a >= 'h9C && a < 'h9C + 4 * NB) begin
         kind = 7; bank = (a - 'h9C) / 4;
         return 1;
      end
      return 0;
   endfunction

   function automatic bit [31:0] m_read(input int a);
      int k, b;
      if (!map_addr(a, k, b)) return 0;
      case (k)
         0: return m_s2[b*32 +: 32];
         1: return m_dir[b];
         2, 3: return m_out[b];
         4: return m_rise[b];
         5: return m_fall[b];
         6: return m_stat[b];
         default: return m_mask[b];
      endcase
   endfunction

   always @(posedge clk) begin
      int k, b;
      bit [31:0] hit [NB];
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin
            m_dir[i] = 0; m_out[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
            m_stat[i] = 0; m_mask[i] = 32'hFFFF_FFFF;
         end
         m_s1 = 0; m_s2 = 0; m_prev = 0;
      end else begin
         for (int i = 0; i < NB; i++) begin
            hit[i] = 0;
            for (int j = 0; j < 32; j++) begin
               if (m_s2[i*32+j] && !m_prev[i*32+j] && m_rise[i][j]) hit[i][j] = 1;
               if (!m_s2[i*32+j] && m_prev[i*32+j] && m_fall[i][j]) hit[i][j] = 1;
            end
         end
         if (bus_we && map_addr(int'(bus_addr), k, b)) begin
            case (k)
               1: m_dir[b] = bus_wdata;
               2: m_out[b] = m_out[b] | bus_wdata;
               3: m_out[b] = m_out[b] & ~bus_wdata;
               4: m_rise[b] = bus_wdata;
               5: m_fall[b] = bus_wdata;
               6: m_stat[b] = m_stat[b] & ~bus_wdata;
               7: m_mask[b] = bus_wdata;
               default: ;
            endcase
         end
         for (int i = 0; i < NB; i++) m_stat[i] = m_stat[i] | hit[i];
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      end
   end

   task automatic chk(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      bit any;
      bit [NP-1:0] e_out, e_oe;
      #5;
      any = 0;
      for (int i = 0; i < NB; i++) begin
         e_out[i*32 +: 32] = m_out[i];
         e_oe[i*32 +: 32]  = m_dir[i];
         if ((m_stat[i] & m_mask[i]) != 0) any = 1;
      end
      chk("R3 pad_out", pad_out, e_out);
      chk("R5 pad_oe", pad_oe, e_oe);
      chk("R10 irq", NP'(irq), NP'(any));
      chk("R1 rdata", NP'(bus_rdata), NP'(m_read(int'(bus_addr))));
   end

   task automatic wr(input int a, input bit [31:0] d);
      @(negedge clk);
      bus_addr = 8'(a); bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'h60;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 8'(a); bus_we = 1'b0;
      @(posedge clk); #5;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
         end
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      // R2 reset state
      @(posedge clk); #5;
      chk("R2 pad_out", pad_out, '0);
      chk("R2 pad_oe", pad_oe, '0);
      chk("R2 irq", NP'(irq), '0);
      rd('h9C, v); chk("R2 mask b0", NP'(v), NP'(32'hFFFF_FFFF));
      rd('hA4, v); chk("R2 mask b2", NP'(v), NP'(32'hFFFF_FFFF));
      rd('h4C, v); chk("R2 status b1", NP'(v), '0);

      // R3 / R4 set and clear on bank 1
      wr('h1C, 32'h0000_00F0);
      rd('h1C, v); chk("R3 set", NP'(v), NP'(32'hF0));
      wr('h1C, 32'h0000_000F);
      rd('h28, v); chk("R3 set keeps zeros", NP'(v), NP'(32'hFF));
      wr('h28, 32'h0000_0030);
      rd('h1C, v); chk("R4 clear", NP'(v), NP'(32'hCF));
      chk("R4 pad_out b1", NP'(pad_out[63:32]), NP'(32'hCF));

      // R5 direction
      wr('h0C, 32'h0000_0055);
      @(posedge clk); #5;
      chk("R5 pad_oe b0", NP'(pad_oe[31:0]), NP'(32'h55));

      // R6 level readback with pins driven as outputs
      wr('h14, 32'hFFFF_FFFF);
      wr('h08, 32'h1234_5678);
      @(negedge clk); pad_in = {32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D};
      idle(3);
      rd('h08, v); chk("R6 level b2", NP'(v), NP'(32'hDEAD_BEEF));
      rd('h00, v); chk("R6 level b0", NP'(v), NP'(32'hCAFE_F00D));
      @(negedge clk); pad_in = '0;
      idle(4);

      // R7 edge polarity
      wr('h30, 32'h1);
      wr('h3C, 32'h2);
      @(negedge clk); pad_in[1:0] = 2'b11;
      idle(4);
      rd('h48, v); chk("R7 rising only bit0", NP'(v), NP'(32'h1));
      @(negedge clk); pad_in[1] = 1'b0;
      idle(4);
      rd('h48, v); chk("R7 falling bit1", NP'(v), NP'(32'h3));
      @(negedge clk); pad_in[0] = 1'b0;
      idle(4);
      rd('h48, v); chk("R7 disabled fall ignored", NP'(v), NP'(32'h3));

      // R10 interrupt and mask
      @(posedge clk); #5; chk("R10 irq on", NP'(irq), NP'(1));
      wr('h9C, 32'h0);
      @(posedge clk); #5; chk("R10 masked", NP'(irq), '0);
      wr('h9C, 32'hFFFF_FFFF);

      // R8 write-one clear
      wr('h48, 32'h2);
      rd('h48, v); chk("R8 clear bit1", NP'(v), NP'(32'h1));
      wr('h48, 32'h0);
      rd('h48, v); chk("R8 zero write", NP'(v), NP'(32'h1));
      wr('h48, 32'h1);
      rd('h48, v); chk("R8 clear bit0", NP'(v), '0);
      @(posedge clk); #5; chk("R10 irq off", NP'(irq), '0);

      // R9 set wins over a same-cycle clear
      wr('h3C, 32'h3);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(4);
      rd('h48, v); chk("R9 prep", NP'(v), NP'(32'h1));
      @(negedge clk); pad_in[0] = 1'b0;
      @(negedge clk);
      @(negedge clk); bus_addr = 8'h48; bus_we = 1'b1; bus_wdata = 32'h1;
      @(negedge clk); bus_we = 1'b0;
      idle(2);
      rd('h48, v); chk("R9 set wins", NP'(v), NP'(32'h1));
      wr('h48, 32'h1);
      rd('h48, v); chk("R9 clears later", NP'(v), '0);

      // R1 stride between banks
      wr('h38, 32'h0000_00A5);
      rd('h38, v); chk("R1 rise b2", NP'(v), NP'(32'hA5));
      rd('h34, v); chk("R1 rise b1 untouched", NP'(v), '0);
      wr('hA0, 32'h0000_FFFF);
      rd('hA0, v); chk("R1 mask b1", NP'(v), NP'(32'hFFFF));

      // R11 unmapped and misaligned
      wr('h58, 32'hFFFF_FFFF);
      rd('h58, v); chk("R11 unmapped read", NP'(v), '0);
      wr('h0D, 32'hFFFF_FFFF);
      rd('h0D, v); chk("R11 misaligned read", NP'(v), '0);
      rd('h0C, v); chk("R11 dir unchanged", NP'(v), NP'(32'h55));
      rd('hA8, v); chk("R11 past mask", NP'(v), '0);
      rd('h04, v); chk("R6 level write ignored", NP'(v), '0);

      idle(2);
      finish_run();
   end

endmodule